// File: doc/BRIEF.md
# Station Address Exact-Match Filter

This block decides, for every received frame, whether its destination address equals a 48-bit station address held inside the block. Software programs that address through two registers: a control register and a 16-bit data register. The control register carries a word index that steers the next data write into one third of the address. It also carries a filter-enable bit and an exact-match mode bit. The usual loading sequence is: clear the control register, load the three words, then set the enable and mode bits in one final control write.

Received bytes arrive one per cycle on a byte stream. The stream is qualified by a valid strobe and marked by start-of-frame and end-of-frame flags. The block follows the first six bytes of each frame. The cycle after the sixth byte, it gives a one-cycle accept or reject pulse. A frame that ends before six bytes is always rejected. The cycle after its final byte, the block gives a one-cycle reject pulse. The comparison core is built as one of two variants, chosen by a parameter: a running compare that keeps one mismatch bit, or a capture of the first five bytes followed by a wide compare.

Top module: `pmf_addr_filter`

## Requirements
- R1: After reset, both verdict outputs are low. The stored address is all zero, and the control state is cleared: filter disabled, mode off, word index 0.
- R2: A control write (`reg_sel`=0) sets the word index from `reg_wdata[9:0]`. A later data write (`reg_sel`=1) loads address bytes k and k+1 when the index equals k, for k = 0, 2 or 4. The words may be loaded in any order.
- R3: In a data write, `reg_wdata[7:0]` becomes the lower-numbered address byte and `reg_wdata[15:8]` becomes the next byte.
- R4: A data write while the index holds any value other than 0, 2 or 4 leaves the stored address unchanged.
- R5: `reg_wdata[31]` of a control write enables the filter and `reg_wdata[27]` selects exact matching. With both set, a frame is accepted when frame bytes 0..5 equal address bytes 0..5, in that order.
- R6: With both bits set, a frame that differs from the stored address in any one of its first six bytes is rejected.
- R7: With the filter enabled and the mode bit clear, every frame of six or more bytes is rejected.
- R8: With the filter disabled, every frame of six or more bytes is accepted, whatever its contents.
- R9: A frame whose end-of-frame byte comes before its sixth byte is rejected. The reject pulse comes in the cycle after that last byte, in every control setting.
- R10: Each frame produces exactly one verdict pulse, one cycle long. For frames of six or more bytes, the pulse comes in the cycle after the sixth valid byte. Idle cycles inside a frame, bytes after the sixth, and valid bytes outside any frame produce no pulse.
- R11: A start-of-frame flag in the middle of a frame discards the bytes seen so far, and counting restarts at that byte.
- R12: `match_accept` and `match_reject` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 the data register |
| reg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| match_accept | output | 1 | One-cycle pulse: frame accepted |
| match_reject | output | 1 | One-cycle pulse: frame rejected |

## Verification
The hardest cases to reach are those where the verdict depends on bytes from separate cycles: a frame that matches in five bytes and differs only in the sixth, a frame broken up by idle cycles, and a frame restarted by a second start-of-frame after five matching bytes. The bench sweeps the mismatch position over all six bytes under each of the four enable/mode settings, adds idle gaps on alternate frames, and records the byte position of every pulse. A pulse that is late, early or doubled is therefore caught as well as a wrong verdict. Swapped byte lanes and writes at unused indices are tested by loading the address and then sending a frame that matches only the intended layout.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
   localparam int unsigned PMF_BYTE_W = 8;

   typedef enum logic [1:0] {
      VERDICT_NONE   = 2'd0,
      VERDICT_ACCEPT = 2'd1,
      VERDICT_REJECT = 2'd2
   } verdict_e;

   // Compare-core variants selectable at elaboration
   localparam int unsigned PMF_IMPL_RUNNING = 0;
   localparam int unsigned PMF_IMPL_CAPTURE = 1;
endpackage

// File: rtl/pmf_addr_store.sv
module pmf_addr_store #(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned IDX_W      = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    idx_wr,
   input  logic [IDX_W-1:0]        idx_val,
   input  logic                    data_wr,
   input  logic [WORD_W-1:0]       data_val,
   output logic [ADDR_BYTES*8-1:0] addr_q
);
   localparam int unsigned BPW   = WORD_W / 8;
   localparam int unsigned WORDS = ADDR_BYTES / BPW;

   if (WORD_W % 8 != 0) begin : g_chk_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (ADDR_BYTES % BPW != 0) begin : g_chk_split
      $error("ADDR_BYTES must be a multiple of the word size in bytes");
   end
   if ((1 << IDX_W) <= ADDR_BYTES) begin : g_chk_idx
      $error("IDX_W too narrow for the address index");
   end

   logic [IDX_W-1:0] idx_q;
   logic [WORDS-1:0] word_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= '0;
      else if (idx_wr) idx_q <= idx_val;
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign word_hit[w] = (idx_q == IDX_W'(w * BPW));
      always_ff @(posedge clk) begin
         if (!rst_n)
            addr_q[w*WORD_W +: WORD_W] <= '0;
         else if (data_wr && word_hit[w])
            addr_q[w*WORD_W +: WORD_W] <= data_val;
      end
   end

   // R4: data writes at an unused index do not disturb the address
   p_bad_index_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !(|word_hit)) |=> $stable(addr_q));
   // R2: the index decode picks at most one word
   p_word_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(word_hit));
endmodule

// File: rtl/pmf_frame_tracker.sv
module pmf_frame_tracker #(
   parameter int unsigned ADDR_BYTES = 6,
   localparam int unsigned CNT_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_sof,
   input  logic             rx_eof,
   output logic             byte_live,
   output logic [CNT_W-1:0] byte_idx,
   output logic             decide,
   output logic             runt_end
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

   if (ADDR_BYTES < 2) begin : g_chk_len
      $error("ADDR_BYTES must be at least 2");
   end

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   assign byte_live = rx_valid && (rx_sof || active_q);
   assign byte_idx  = rx_sof ? '0 : cnt_q;
   assign decide    = byte_live && (byte_idx == LAST_IDX);
   assign runt_end  = byte_live && rx_eof && (byte_idx < LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (byte_live) begin
         if (decide || rx_eof) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            active_q <= 1'b1;
            cnt_q    <= byte_idx + 1'b1;
         end
      end
   end

   // R10: the position counter never walks past the decision byte
   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_IDX);
   // R10: once a verdict is due, tracking stops until the next start
   p_idle_after_decide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      decide |=> !active_q);
   // R11: a start flag always restarts the count at the following byte
   p_sof_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_sof && !rx_eof) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/pmf_match_eval.sv
module pmf_match_eval #(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned MATCH_IMPL = 0,
   localparam int unsigned CNT_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_live,
   input  logic [CNT_W-1:0]        byte_idx,
   input  logic [7:0]              rx_data,
   input  logic [ADDR_BYTES*8-1:0] addr_q,
   output logic                    full_match
);
   import pmf_pkg::*;

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

   if (MATCH_IMPL != PMF_IMPL_RUNNING && MATCH_IMPL != PMF_IMPL_CAPTURE) begin : g_chk_impl
      $error("MATCH_IMPL selects an unknown compare variant");
   end

   logic [7:0] addr_b [ADDR_BYTES];
   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_split
      assign addr_b[k] = addr_q[k*8 +: 8];
   end

   if (MATCH_IMPL == PMF_IMPL_RUNNING) begin : g_running
      logic       miss_q;
      logic       prior_miss;
      logic [7:0] exp_byte;
      logic       cur_ok;

      always_comb begin
         exp_byte = '0;
         for (int k = 0; k < ADDR_BYTES; k++)
            if (byte_idx == CNT_W'(k)) exp_byte = addr_b[k];
      end

      assign cur_ok     = (rx_data == exp_byte);
      assign prior_miss = (byte_idx == '0) ? 1'b0 : miss_q;
      assign full_match = !prior_miss && cur_ok;

      always_ff @(posedge clk) begin
         if (!rst_n) miss_q <= 1'b0;
         else if (byte_live) miss_q <= prior_miss || !cur_ok;
      end

      // R6: a mismatch seen mid-frame is kept until the next first byte
      p_miss_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (miss_q && !byte_live) |=> miss_q);
   end else begin : g_capture
      logic [7:0] cap_q [ADDR_BYTES-1];
      logic       head_ok;

      for (genvar k = 0; k < ADDR_BYTES - 1; k++) begin : g_cap
         always_ff @(posedge clk) begin
            if (!rst_n) cap_q[k] <= '0;
            else if (byte_live && byte_idx == CNT_W'(k)) cap_q[k] <= rx_data;
         end
      end

      always_comb begin
         head_ok = 1'b1;
         for (int k = 0; k < ADDR_BYTES - 1; k++)
            if (cap_q[k] != addr_b[k]) head_ok = 1'b0;
      end

      assign full_match = head_ok && (rx_data == addr_b[ADDR_BYTES-1]);

      // R5: a held byte changes only when a live byte lands on its slot
      p_cap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !byte_live |=> $stable(cap_q[0]));
   end

   // R5: the compare result is meaningful only on the decision byte
   p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_live |-> (byte_idx <= LAST_IDX));
endmodule

// File: rtl/pmf_addr_filter.sv
module pmf_addr_filter #(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned IDX_W      = 10,
   parameter int unsigned EN_BIT     = 31,
   parameter int unsigned PM_BIT     = 27,
   parameter int unsigned MATCH_IMPL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             rx_valid,
   input  logic             rx_sof,
   input  logic             rx_eof,
   input  logic [7:0]       rx_data,
   output logic             match_accept,
   output logic             match_reject
);
   import pmf_pkg::*;

   localparam int unsigned CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

   if (EN_BIT >= REG_W || PM_BIT >= REG_W) begin : g_chk_bits
      $error("control bit positions exceed REG_W");
   end
   if (EN_BIT == PM_BIT || EN_BIT < IDX_W || PM_BIT < IDX_W) begin : g_chk_overlap
      $error("control fields overlap");
   end
   if (WORD_W > REG_W) begin : g_chk_word
      $error("WORD_W exceeds REG_W");
   end

   logic                    ctrl_wr, data_wr;
   logic                    en_q, pm_q;
   logic [ADDR_BYTES*8-1:0] addr_q;
   logic                    byte_live, decide, runt_end, full_match;
   logic [CNT_W-1:0]        byte_idx;
   verdict_e                verdict_d, verdict_q;
   logic                    unused_wbits;

   assign ctrl_wr      = reg_wr && !reg_sel;
   assign data_wr      = reg_wr && reg_sel;
   assign unused_wbits = ^reg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         pm_q <= 1'b0;
      end else if (ctrl_wr) begin
         en_q <= reg_wdata[EN_BIT];
         pm_q <= reg_wdata[PM_BIT];
      end
   end

   pmf_addr_store #(
      .ADDR_BYTES(ADDR_BYTES), .WORD_W(WORD_W), .IDX_W(IDX_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (ctrl_wr),
      .idx_val (reg_wdata[IDX_W-1:0]),
      .data_wr (data_wr),
      .data_val(reg_wdata[WORD_W-1:0]),
      .addr_q  (addr_q)
   );

   pmf_frame_tracker #(.ADDR_BYTES(ADDR_BYTES)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_sof   (rx_sof),
      .rx_eof   (rx_eof),
      .byte_live(byte_live),
      .byte_idx (byte_idx),
      .decide   (decide),
      .runt_end (runt_end)
   );

   pmf_match_eval #(.ADDR_BYTES(ADDR_BYTES), .MATCH_IMPL(MATCH_IMPL)) u_eval (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_live (byte_live),
      .byte_idx  (byte_idx),
      .rx_data   (rx_data),
      .addr_q    (addr_q),
      .full_match(full_match)
   );

   always_comb begin
      verdict_d = VERDICT_NONE;
      if (runt_end)
         verdict_d = VERDICT_REJECT;
      else if (decide) begin
         if (!en_q || (pm_q && full_match)) verdict_d = VERDICT_ACCEPT;
         else                               verdict_d = VERDICT_REJECT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) verdict_q <= VERDICT_NONE;
      else        verdict_q <= verdict_d;
   end

   assign match_accept = (verdict_q == VERDICT_ACCEPT);
   assign match_reject = (verdict_q == VERDICT_REJECT);

   // R12: the two verdicts exclude each other
   p_excl_verdict_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(match_accept && match_reject));
   // R10: an accept lasts one cycle
   p_accept_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      match_accept |=> !match_accept);
   // R10: any verdict follows a valid byte
   p_verdict_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (match_accept || match_reject) |-> $past(rx_valid));
   // R8: disabled filter accepts complete frames
   p_disabled_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !en_q) |=> match_accept);
   // R9: a short frame ends in a reject
   p_runt_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
      runt_end |=> match_reject);
   // R7: enabled without exact mode never accepts
   p_no_mode_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && en_q && !pm_q) |=> match_reject);
endmodule

// File: tb/tb_pmf_addr_filter.sv
`timescale 1ns/1ps
module tb_pmf_addr_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        match_accept, match_reject;

   int checks = 0, failures = 0;
   int nacc, nrej, acc_pos, rej_pos, cur_pos, both_hi;
   bit finished = 0;
   logic [7:0] fb [16];
   logic [7:0] adr [6];

   always #4 clk = ~clk;

   pmf_addr_filter dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_data(rx_data),
      .match_accept(match_accept), .match_reject(match_reject)
   );

   task automatic check(bit ok, string req, string act, string exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   task automatic observe();
      if (match_accept) begin nacc++; acc_pos = cur_pos; end
      if (match_reject) begin nrej++; rej_pos = cur_pos; end
      if (match_accept && match_reject) both_hi++;
   endtask

   task automatic clear_obs();
      nacc = 0; nrej = 0; acc_pos = -1; rej_pos = -1; both_hi = 0;
   endtask

   task automatic wreg(bit sel, logic [31:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
   endtask

   task automatic put_byte(logic [7:0] d, bit s, bit e);
      rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_eof = e;
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
      observe();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         observe();
      end
   endtask

   task automatic ctrl(bit en, bit pm, int idx);
      wreg(1'b0, (32'(en) << 31) | (32'(pm) << 27) | 32'(idx));
   endtask

   task automatic load_addr(int o0, int o1, int o2);
      int ord [3];
      ord[0] = o0; ord[1] = o1; ord[2] = o2;
      ctrl(0, 0, 0);
      for (int j = 0; j < 3; j++) begin
         ctrl(0, 0, ord[j] * 2);
         wreg(1'b1, {16'hBEEF, adr[ord[j]*2+1], adr[ord[j]*2]});
      end
   endtask

   // Sends fb[0..len-1]; eof on last byte; gaps insert idle cycles
   task automatic send(int len, bit gaps);
      for (int i = 0; i < len; i++) begin
         cur_pos = i;
         put_byte(fb[i], i == 0, i == len - 1);
         if (gaps && (i % 2 == 1)) begin cur_pos = 100 + i; idle(1); end
      end
      cur_pos = 200;
      idle(3);
   endtask

   function automatic bit model_accept(bit en, bit pm, int len);
      bit eq = 1'b1;
      for (int k = 0; k < 6; k++) if (fb[k] != adr[k]) eq = 1'b0;
      if (len < 6) return 1'b0;
      if (!en) return 1'b1;
      if (!pm) return 1'b0;
      return eq;
   endfunction

   task automatic judge(string req, bit exp_acc, int len);
      int pos = (len < 6) ? len - 1 : 5;
      bit ok;
      if (exp_acc) ok = (nacc == 1 && nrej == 0 && acc_pos == pos);
      else         ok = (nacc == 0 && nrej == 1 && rej_pos == pos);
      ok = ok && (both_hi == 0);
      check(ok, req,
            $sformatf("acc=%0d rej=%0d apos=%0d rpos=%0d", nacc, nrej, acc_pos, rej_pos),
            $sformatf("%s at pos %0d", exp_acc ? "accept" : "reject", pos));
   endtask

   task automatic frame_of_addr(int len);
      for (int k = 0; k < 16; k++) fb[k] = (k < 6) ? adr[k] : 8'(8'h40 + k);
      if (len < 0) fb[0] = 8'h00;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      clear_obs(); cur_pos = 300;
      idle(4);
      // R1: quiet outputs after reset
      check(nacc == 0 && nrej == 0, "R1", $sformatf("%0d/%0d", nacc, nrej), "0/0");

      // R1: reset address is zero; exact match of six zero bytes
      for (int k = 0; k < 6; k++) adr[k] = 8'h00;
      frame_of_addr(8);
      clear_obs(); send(8, 0);
      judge("R1 R8 reset disabled accepts", 1'b1, 8);
      ctrl(1, 1, 0);
      clear_obs(); send(6, 0);
      judge("R1 zero address match", 1'b1, 6);

      // Load address A, words in order 0,1,2
      for (int k = 0; k < 6; k++) adr[k] = 8'(8'h1D * (k + 1) + 8'h05);
      load_addr(0, 1, 2);

      // R5 R6 R7 R8: sweep settings x mismatch position
      for (int s = 0; s < 4; s++) begin
         for (int mp = -1; mp < 6; mp++) begin
            bit en = s[1], pm = s[0];
            int len = 6 + ((mp + 1) % 3);
            bit exp_acc;
            ctrl(en, pm, 4);
            frame_of_addr(len);
            if (mp >= 0) fb[mp] = fb[mp] ^ 8'(8'h01 << mp);
            exp_acc = model_accept(en, pm, len);
            clear_obs(); send(len, (mp + s) % 2 == 1);
            if (en && pm) judge(mp < 0 ? "R5 exact match" : "R6 byte mismatch", exp_acc, len);
            else if (en)  judge("R7 mode off rejects", exp_acc, len);
            else          judge("R8 disabled accepts", exp_acc, len);
         end
      end

      // R9: short frames rejected under every setting
      for (int s = 0; s < 4; s++) begin
         for (int len = 1; len < 6; len++) begin
            ctrl(s[1], s[0], 0);
            frame_of_addr(len);
            clear_obs(); send(len, len % 2 == 0);
            judge("R9 runt", 1'b0, len);
         end
      end

      // R3: byte lanes; swapped word frame must not match
      ctrl(1, 1, 0);
      frame_of_addr(6);
      fb[0] = adr[1]; fb[1] = adr[0];
      clear_obs(); send(6, 0);
      judge("R3 swapped lanes rejected", adr[0] == adr[1], 6);

      // R4: writes at unused indices leave address intact
      for (int bi = 1; bi < 9; bi += 2) begin
         ctrl(0, 0, bi);
         wreg(1'b1, 32'h0000FFFF);
      end
      ctrl(0, 0, 6); wreg(1'b1, 32'h0000A5A5);
      ctrl(0, 0, 512); wreg(1'b1, 32'h00005A5A);
      ctrl(1, 1, 0);
      frame_of_addr(6);
      clear_obs(); send(6, 0);
      judge("R4 unused index ignored", 1'b1, 6);

      // R2: reload address B in order 2,0,1
      for (int k = 0; k < 6; k++) adr[k] = 8'(8'hC3 - 8'd17 * k);
      load_addr(2, 0, 1);
      ctrl(1, 1, 2);
      frame_of_addr(7);
      clear_obs(); send(7, 1);
      judge("R2 out-of-order load matches", 1'b1, 7);

      // R11: restart after five matching bytes with no eof
      clear_obs();
      for (int i = 0; i < 5; i++) begin
         cur_pos = 50 + i;
         put_byte(adr[i], i == 0, 1'b0);
      end
      frame_of_addr(6);
      fb[2] = ~fb[2];
      send(6, 0);
      judge("R11 restart discards prefix", 1'b0, 6);

      // R10: stray bytes without a start produce nothing
      clear_obs();
      cur_pos = 400;
      for (int i = 0; i < 8; i++) put_byte(adr[i % 6], 1'b0, i == 7);
      idle(2);
      check(nacc == 0 && nrej == 0, "R10 no frame no pulse",
            $sformatf("%0d/%0d", nacc, nrej), "0/0");

      // R12 R10: back-to-back matching frames, one pulse each
      clear_obs();
      for (int f = 0; f < 3; f++) begin
         for (int i = 0; i < 6; i++) begin
            cur_pos = i;
            put_byte(adr[i], i == 0, i == 5);
         end
      end
      cur_pos = 200; idle(2);
      check(nacc == 3 && nrej == 0 && both_hi == 0, "R10 R12 back-to-back",
            $sformatf("acc=%0d rej=%0d both=%0d", nacc, nrej, both_hi), "acc=3 rej=0 both=0");

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule